// File: doc/BRIEF.md
# Match-Reload Timer Bank with Snapshot Read

This block holds a bank of three 32-bit up-counters, programmed over a simple single-cycle register bus. Each counter has three match comparators, a preload value, and a reload selector. The selector names which of that counter's own comparators, if any, makes it load the preload value in place of incrementing. A hit on any comparator sets a sticky status flag, and software clears the flag by writing a one to it. One bit per counter in an enable register starts and stops it.

A counter advances on its count tick. By default the tick is the slow `cntTick` strobe, which comes from the function clock. A clock-select bit can make the counter advance on every bus clock cycle instead. Because the count moves on the slow tick, software reads it through a snapshot register. Writing a one requests a capture, the capture is made two count ticks later, and reads return the captured value until the next capture.

Top module: `mrt_top`

## Requirements
- R1: After reset, every match, preload, reload-select, clock-select, enable, status, count and snapshot register reads 0.
- R2: Enable register at word address 19 has bit t for timer t. Clock-select register at address 0 has bit t: 0 makes timer t advance once per cycle with `cntTick` high, 1 makes it advance every clock cycle. A disabled timer holds its count.
- R3: Reload select for timer t at address 16+t. A value s in 1..3 picks comparator s-1 of that timer. On a tick where the count equals that comparator's match value, the counter loads the preload value (address 13+t) instead of incrementing. A value of 0 disables reload.
- R4: With match 0xFFFFFFFF, preload 0 and select 1, the counter steps from 0xFFFFFFFF to 0 and continues counting from there.
- R5: The match value for comparator k of timer t is at word address 1+3t+k. Status bit 3t+k (register at address 23) becomes 1 after a tick on which the count equals that match value, and stays set.
- R6: Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged. A set from a tick in the same cycle wins over a clear.
- R7: Writing a value with bit 0 set to address 20+t requests a snapshot of timer t. The snapshot is taken on the second tick of that timer after the request, with the count held just before that tick. Reads of 20+t return the last snapshot, so a read before capture returns the old value. A write with bit 0 clear requests nothing.
- R8: The live count of timer t reads at address 10+t. Writes there are ignored.
- R9: Reads of an unmapped address return 0.
- R10: Ticks, writes and snapshots for one timer leave the other timers' counts and snapshots unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntTick | input | 1 | Slow count tick strobe from the function clock |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| addr | input | 5 | Word address for writes and reads |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |

## Verification
Every counter state is visible at the live count address after the next tick. A wrong increment or a missed reload therefore shows as a wrong count on the first read after the faulty tick. A broken snapshot stage shows up in the cycle it acts: the captured value is off by one tick, or it appears a tick early, so the read between the two ticks already shows the new value. A status flag that fails to hold or to clear is visible on the next status read. A set-versus-clear ordering fault is visible only when a clear and a matching tick land in the same cycle, so that case is driven on purpose.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  localparam int NumTmr   = 3;
  localparam int NumCmp   = 3;
  localparam int CntW     = 32;
  localparam int DataW    = 32;
  localparam int AddrW    = 5;
  localparam int CmpTotal = NumTmr * NumCmp;
  localparam int SelW     = $clog2(NumCmp + 1);

  // Word address map, each block follows the previous one
  localparam int AdrClk    = 0;
  localparam int AdrMatch  = AdrClk + 1;
  localparam int AdrCount  = AdrMatch + CmpTotal;
  localparam int AdrPre    = AdrCount + NumTmr;
  localparam int AdrPreCtl = AdrPre + NumTmr;
  localparam int AdrEn     = AdrPreCtl + NumTmr;
  localparam int AdrSnap   = AdrEn + 1;
  localparam int AdrStat   = AdrSnap + NumTmr;

  typedef struct packed {
    logic [NumTmr-1:0]   snapReq;
    logic [CmpTotal-1:0] statClr;
  } strobe_t;

  typedef struct packed {
    logic [NumTmr-1:0]                 fastClk;
    logic [NumTmr-1:0]                 run;
    logic [NumTmr-1:0][SelW-1:0]       reloadSel;
    logic [NumTmr-1:0][CntW-1:0]       preload;
    logic [CmpTotal-1:0][CntW-1:0]     match;
  } cfg_t;
endpackage

// File: rtl/mrt_counter.sv
module mrt_counter
  import mrt_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         tick,
  input  logic [NumCmp-1:0][CntW-1:0]  match,
  input  logic [CntW-1:0]              preload,
  input  logic [SelW-1:0]              reloadSel,
  input  logic                         snapReq,
  input  logic [NumCmp-1:0]            statClr,
  output logic [CntW-1:0]              count,
  output logic [CntW-1:0]              snap,
  output logic [NumCmp-1:0]            status
);
  logic [NumCmp-1:0] hit;
  logic              reloadHit;
  logic              reqPend;
  logic              stageQ;

  always_comb begin
    reloadHit = 1'b0;
    for (int k = 0; k < NumCmp; k++) begin
      hit[k] = (count == match[k]);
      if (reloadSel == SelW'(k + 1) && hit[k]) reloadHit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      snap    <= '0;
      status  <= '0;
      reqPend <= 1'b0;
      stageQ  <= 1'b0;
    end else begin
      if (tick) begin
        count  <= reloadHit ? preload : count + 1'b1;
        stageQ <= reqPend;
        if (stageQ) snap <= count;
      end
      reqPend <= snapReq | (reqPend & ~tick);
      status  <= (status & ~statClr) | ({NumCmp{tick}} & hit);
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(count));

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && reloadSel == SelW'(1) && count == match[0]) |=> count == $past(preload));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && reloadSel == '0) |=> count == $past(count) + 1'b1);

  assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(snap));

  for (genvar k = 0; k < NumCmp; k++) begin : g_statChk
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
      (status[k] && !statClr[k]) |=> status[k]);
    assert_set_R5: assert property (@(posedge clk) disable iff (!rstN)
      (tick && count == match[k]) |=> status[k]);
  end
endmodule

// File: rtl/mrt_datapath.sv
module mrt_datapath
  import mrt_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cntTick,
  input  cfg_t                        cfg,
  input  strobe_t                     strb,
  output logic [NumTmr-1:0][CntW-1:0] count,
  output logic [NumTmr-1:0][CntW-1:0] snap,
  output logic [CmpTotal-1:0]         status
);
  logic [NumTmr-1:0] tick;

  for (genvar t = 0; t < NumTmr; t++) begin : g_tmr
    assign tick[t] = cfg.run[t] & (cfg.fastClk[t] | cntTick);

    mrt_counter u_cnt (
      .clk       (clk),
      .rstN      (rstN),
      .tick      (tick[t]),
      .match     (cfg.match[t*NumCmp +: NumCmp]),
      .preload   (cfg.preload[t]),
      .reloadSel (cfg.reloadSel[t]),
      .snapReq   (strb.snapReq[t]),
      .statClr   (strb.statClr[t*NumCmp +: NumCmp]),
      .count     (count[t]),
      .snap      (snap[t]),
      .status    (status[t*NumCmp +: NumCmp])
    );
  end

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.run[0] |=> $stable(count[0]));
endmodule

// File: rtl/mrt_ctrl.sv
module mrt_ctrl
  import mrt_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [AddrW-1:0]            addr,
  input  logic [DataW-1:0]            wrData,
  input  logic [NumTmr-1:0][CntW-1:0] count,
  input  logic [NumTmr-1:0][CntW-1:0] snap,
  input  logic [CmpTotal-1:0]         status,
  output cfg_t                        cfg,
  output strobe_t                     strb,
  output logic [DataW-1:0]            rdData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (wrEn) begin
      if (addr == AddrW'(AdrClk)) cfg.fastClk <= wrData[NumTmr-1:0];
      if (addr == AddrW'(AdrEn))  cfg.run     <= wrData[NumTmr-1:0];
      for (int i = 0; i < CmpTotal; i++)
        if (addr == AddrW'(AdrMatch + i)) cfg.match[i] <= wrData[CntW-1:0];
      for (int t = 0; t < NumTmr; t++) begin
        if (addr == AddrW'(AdrPre + t))    cfg.preload[t]   <= wrData[CntW-1:0];
        if (addr == AddrW'(AdrPreCtl + t)) cfg.reloadSel[t] <= wrData[SelW-1:0];
      end
    end
  end

  always_comb begin
    for (int t = 0; t < NumTmr; t++)
      strb.snapReq[t] = wrEn && (addr == AddrW'(AdrSnap + t)) && wrData[0];
    strb.statClr = (wrEn && addr == AddrW'(AdrStat)) ? wrData[CmpTotal-1:0] : '0;
  end

  always_comb begin
    rdData = '0;
    if (addr == AddrW'(AdrClk))  rdData = DataW'(cfg.fastClk);
    if (addr == AddrW'(AdrEn))   rdData = DataW'(cfg.run);
    if (addr == AddrW'(AdrStat)) rdData = DataW'(status);
    for (int i = 0; i < CmpTotal; i++)
      if (addr == AddrW'(AdrMatch + i)) rdData = DataW'(cfg.match[i]);
    for (int t = 0; t < NumTmr; t++) begin
      if (addr == AddrW'(AdrCount + t))  rdData = DataW'(count[t]);
      if (addr == AddrW'(AdrPre + t))    rdData = DataW'(cfg.preload[t]);
      if (addr == AddrW'(AdrPreCtl + t)) rdData = DataW'(cfg.reloadSel[t]);
      if (addr == AddrW'(AdrSnap + t))   rdData = DataW'(snap[t]);
    end
  end

  assert_snap_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.snapReq));

  assert_clr_only_on_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> strb.statClr == '0);
endmodule

// File: rtl/mrt_top.sv
module mrt_top
  import mrt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntTick,
  input  logic             wrEn,
  input  logic [AddrW-1:0] addr,
  input  logic [DataW-1:0] wrData,
  output logic [DataW-1:0] rdData
);
  cfg_t                        cfg;
  strobe_t                     strb;
  logic [NumTmr-1:0][CntW-1:0] count;
  logic [NumTmr-1:0][CntW-1:0] snap;
  logic [CmpTotal-1:0]         status;

  mrt_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .count  (count),
    .snap   (snap),
    .status (status),
    .cfg    (cfg),
    .strb   (strb),
    .rdData (rdData)
  );

  mrt_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cntTick (cntTick),
    .cfg     (cfg),
    .strb    (strb),
    .count   (count),
    .snap    (snap),
    .status  (status)
  );
endmodule

// File: tb/mrt_top_tb_top.sv
`timescale 1ns/1ps
module mrt_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mrt_top dut_i (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busWriteTick(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; cntTick = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; cntTick = 1'b0;
  endtask

  task automatic readNow(input logic [4:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    readNow(a, v);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cntTick = 1'b1;
      @(negedge clk); cntTick = 1'b0;
    end
  endtask

  task automatic expectReg(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRead(a, v);
    check(req, v, exp);
  endtask

  task automatic testReset();
    for (int a = 0; a < 24; a++) expectReg("R1", 5'(a), 32'h0);
  endtask

  task automatic testCount();
    busWrite(19, 1);
    ticks(5);
    expectReg("R2", 10, 5);
    repeat (4) @(negedge clk);
    expectReg("R2", 10, 5);
    expectReg("R10", 11, 0);
    expectReg("R10", 12, 0);
    busWrite(19, 0);
    ticks(3);
    expectReg("R2", 10, 5);
  endtask

  task automatic testFastClk();
    logic [31:0] a0, a1;
    busWrite(0, 2);
    busWrite(19, 2);
    @(negedge clk); readNow(11, a0);
    repeat (6) @(negedge clk);
    readNow(11, a1);
    check("R2", a1 - a0, 6);
    busWrite(19, 0);
    busWrite(0, 0);
    expectReg("R10", 10, 5);
  endtask

  task automatic testReload();
    busWrite(8, 3);
    busWrite(15, 10);
    busWrite(18, 2);
    busWrite(19, 4);
    ticks(3);
    expectReg("R3", 12, 3);
    ticks(1);
    expectReg("R3", 12, 10);
    ticks(1);
    expectReg("R3", 12, 11);
    busWrite(18, 0);
    busWrite(8, 13);
    ticks(3);
    expectReg("R3", 12, 14);
    busWrite(19, 0);
  endtask

  task automatic testWrap();
    busWrite(13, 32'hFFFF_FFFE);
    busWrite(1, 5);
    busWrite(16, 1);
    busWrite(19, 1);
    ticks(1);
    expectReg("R3", 10, 32'hFFFF_FFFE);
    busWrite(1, 32'hFFFF_FFFF);
    busWrite(13, 0);
    ticks(1);
    expectReg("R4", 10, 32'hFFFF_FFFF);
    ticks(1);
    expectReg("R4", 10, 0);
    ticks(1);
    expectReg("R4", 10, 1);
    busWrite(19, 0);
  endtask

  task automatic testStatus();
    busWrite(23, 32'h1FF);
    expectReg("R6", 23, 0);
    busWrite(3, 3);
    busWrite(19, 1);
    ticks(2);
    expectReg("R5", 23, 0);
    ticks(1);
    expectReg("R5", 23, 32'h4);
    busWrite(23, 0);
    expectReg("R6", 23, 32'h4);
    busWrite(23, 32'h4);
    expectReg("R6", 23, 0);
    busWrite(3, 4);
    busWriteTick(23, 32'h4);
    expectReg("R6", 23, 32'h4);
    expectReg("R5", 10, 5);
  endtask

  task automatic testSnap();
    expectReg("R7", 20, 0);
    busWrite(20, 1);
    expectReg("R7", 20, 0);
    ticks(1);
    expectReg("R7", 20, 0);
    ticks(1);
    expectReg("R7", 20, 6);
    busWrite(20, 32'h2);
    ticks(2);
    expectReg("R7", 20, 6);
    busWrite(20, 1);
    ticks(2);
    expectReg("R7", 20, 10);
    expectReg("R10", 21, 0);
    expectReg("R10", 22, 0);
    expectReg("R10", 12, 14);
  endtask

  task automatic testMisc();
    busWrite(10, 32'h1234);
    expectReg("R8", 10, 11);
    expectReg("R9", 31, 0);
    expectReg("R9", 24, 0);
    expectReg("R2", 19, 1);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCount();
    testFastClk();
    testReload();
    testWrap();
    testStatus();
    testSnap();
    testMisc();
    done = 1'b1;
    finishRun();
  end
endmodule